// File: doc/BRIEF.md
# Toggle-Handshake Global Error Unit

This block keeps the global error state of a larger unit as two registers of equal width. The error register is owned by hardware, and the acknowledge register is owned by software. Hardware reports an error by inverting a bit of the error register. Software acknowledges it by inverting the same bit of the acknowledge register. A bit is outstanding while the two registers hold different values in that position. Error sources present a request mask with a strobe. The unit inverts only the requested bits that are not already outstanding. When at least one bit was newly inverted, it emits a single-cycle global-error pulse, provided that interrupt is enabled.

The same unit also produces the pulse outputs for three other interrupt requests. An event-queue request is gated by its own enable. A command-sync request is never gated. A page-request request is not supported, so it never produces a pulse. Software writes to the acknowledge register are always stored in full. A write that inverts bits that were not outstanding sets a one-cycle misuse flag and has no other effect.

Top module: `toggle_err_unit`

## Requirements
- R1: After reset, errFlags, ackFlags, pendingFlags and every pulse and flag output are zero.
- R2: pendingFlags equals errFlags XOR ackFlags in every bit, so a bit reads 1 while the two registers differ.
- R3: When errReqValid is high, the cycle after it errFlags equals the old errFlags XOR (errReqMask AND NOT pending), so outstanding bits are never inverted again.
- R4: When errReqValid is high but every requested bit is already pending, or the mask is zero, errFlags is unchanged and gerrPulse stays low.
- R5: gerrPulse is high for exactly the one cycle after a request that newly inverted at least one bit, and only when gerrIrqEn was high in the request cycle.
- R6: When ackWrEn is high, the cycle after it ackFlags equals ackWrData in full, including bits that were not pending.
- R7: ackMisuse is high for one cycle after an acknowledge write that inverts at least one bit that was not pending before the write. Apart from this flag, such a write has no effect.
- R8: evtPulse is high in the cycle after evtReq only if evtIrqEn was high in the request cycle.
- R9: syncPulse is high in the cycle after every syncReq, whatever the enables are.
- R10: pageReq never produces a pulse: pagePulse stays low.
- R11: When an acknowledge write and an error request arrive in the same cycle, the pending set used for the request is computed from the newly written acknowledge value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| errReqValid | input | 1 | Error request strobe |
| errReqMask | input | ERR_W | Bits the error sources want to report |
| ackWrEn | input | 1 | Acknowledge register write strobe |
| ackWrData | input | ERR_W | Value written to the acknowledge register |
| gerrIrqEn | input | 1 | Global-error interrupt enable |
| evtIrqEn | input | 1 | Event-queue interrupt enable |
| evtReq | input | 1 | Event-queue interrupt request |
| syncReq | input | 1 | Command-sync interrupt request |
| pageReq | input | 1 | Page-request interrupt request (unsupported) |
| errFlags | output | ERR_W | Error register |
| ackFlags | output | ERR_W | Acknowledge register |
| pendingFlags | output | ERR_W | Outstanding error bits |
| gerrPulse | output | 1 | Global-error interrupt pulse |
| evtPulse | output | 1 | Event-queue interrupt pulse |
| syncPulse | output | 1 | Command-sync interrupt pulse |
| pagePulse | output | 1 | Page-request pulse, held low |
| ackMisuse | output | 1 | Acknowledge write inverted bits that were not pending |

## Verification
A wrong bit in either register shows up on pendingFlags in the same cycle. It also changes which bits the next request may invert, so both registers can be compared against a model one cycle after each strobe. A bad pending computation can also suppress or add a gerrPulse or an ackMisuse on the following edge. Comparing every output against the model on every cycle therefore exposes a corrupted state within one clock of its cause.

// File: rtl/toggle_err_pkg.sv
package toggle_err_pkg;
  typedef struct packed {
    logic ackLoad;
    logic errApply;
  } errStrobes_t;
endpackage

// File: rtl/toggle_err_datapath.sv
module toggle_err_datapath
  import toggle_err_pkg::*;
#(
  parameter int ERR_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  errStrobes_t      strb,
  input  logic [ERR_W-1:0] errReqMask,
  input  logic [ERR_W-1:0] ackWrData,
  output logic [ERR_W-1:0] errFlags,
  output logic [ERR_W-1:0] ackFlags,
  output logic             newAny,
  output logic             misuseAny
);
  logic [ERR_W-1:0] errQ, ackQ, ackNext, pendNext, toggleBits;

  always_comb begin
    ackNext    = strb.ackLoad ? ackWrData : ackQ;
    pendNext   = errQ ^ ackNext;
    toggleBits = errReqMask & ~pendNext;
    newAny     = |toggleBits;
    misuseAny  = |((ackQ ^ ackWrData) & ~(errQ ^ ackQ));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errQ <= '0;
      ackQ <= '0;
    end else begin
      ackQ <= ackNext;
      if (strb.errApply) errQ <= errQ ^ toggleBits;
    end
  end

  assign errFlags = errQ;
  assign ackFlags = ackQ;
endmodule

// File: rtl/toggle_err_control.sv
module toggle_err_control
  import toggle_err_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        errReqValid,
  input  logic        ackWrEn,
  input  logic        newAny,
  input  logic        misuseAny,
  input  logic        gerrIrqEn,
  input  logic        evtIrqEn,
  input  logic        evtReq,
  input  logic        syncReq,
  input  logic        pageReq,
  output errStrobes_t strb,
  output logic        gerrPulse,
  output logic        evtPulse,
  output logic        syncPulse,
  output logic        pagePulse,
  output logic        ackMisuse
);
  logic pageIgnored;

  always_comb begin
    strb.ackLoad  = ackWrEn;
    strb.errApply = errReqValid;
    pageIgnored   = pageReq & 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gerrPulse <= 1'b0;
      evtPulse  <= 1'b0;
      syncPulse <= 1'b0;
      pagePulse <= 1'b0;
      ackMisuse <= 1'b0;
    end else begin
      gerrPulse <= errReqValid & newAny & gerrIrqEn;
      evtPulse  <= evtReq & evtIrqEn;
      syncPulse <= syncReq;
      pagePulse <= pageIgnored;
      ackMisuse <= ackWrEn & misuseAny;
    end
  end
endmodule

// File: rtl/toggle_err_unit.sv
module toggle_err_unit
  import toggle_err_pkg::*;
#(
  parameter int ERR_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             errReqValid,
  input  logic [ERR_W-1:0] errReqMask,
  input  logic             ackWrEn,
  input  logic [ERR_W-1:0] ackWrData,
  input  logic             gerrIrqEn,
  input  logic             evtIrqEn,
  input  logic             evtReq,
  input  logic             syncReq,
  input  logic             pageReq,
  output logic [ERR_W-1:0] errFlags,
  output logic [ERR_W-1:0] ackFlags,
  output logic [ERR_W-1:0] pendingFlags,
  output logic             gerrPulse,
  output logic             evtPulse,
  output logic             syncPulse,
  output logic             pagePulse,
  output logic             ackMisuse
);
  errStrobes_t strb;
  logic newAny, misuseAny;

  toggle_err_control u_ctrl (
    .clk(clk), .rstN(rstN), .errReqValid(errReqValid), .ackWrEn(ackWrEn),
    .newAny(newAny), .misuseAny(misuseAny), .gerrIrqEn(gerrIrqEn),
    .evtIrqEn(evtIrqEn), .evtReq(evtReq), .syncReq(syncReq), .pageReq(pageReq),
    .strb(strb), .gerrPulse(gerrPulse), .evtPulse(evtPulse),
    .syncPulse(syncPulse), .pagePulse(pagePulse), .ackMisuse(ackMisuse)
  );

  toggle_err_datapath #(.ERR_W(ERR_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .errReqMask(errReqMask),
    .ackWrData(ackWrData), .errFlags(errFlags), .ackFlags(ackFlags),
    .newAny(newAny), .misuseAny(misuseAny)
  );

  assign pendingFlags = errFlags ^ ackFlags;
endmodule

// File: rtl/toggle_err_checker.sv
module toggle_err_checker #(
  parameter int ERR_W = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             errReqValid,
  input logic [ERR_W-1:0] errReqMask,
  input logic             ackWrEn,
  input logic [ERR_W-1:0] ackWrData,
  input logic             gerrIrqEn,
  input logic             evtIrqEn,
  input logic             evtReq,
  input logic             syncReq,
  input logic             pageReq,
  input logic [ERR_W-1:0] errFlags,
  input logic [ERR_W-1:0] ackFlags,
  input logic             gerrPulse,
  input logic             evtPulse,
  input logic             syncPulse,
  input logic             pagePulse
);
  // R3 R11: only bits not pending against the updated acknowledge may flip
  a_r3_no_pending_retoggle: assert property (@(posedge clk) disable iff (!rstN)
    errReqValid |=> ((errFlags ^ $past(errFlags)) &
      ($past(errFlags) ^ $past(ackWrEn ? ackWrData : ackFlags))) == '0);
  a_r4_idle_stable: assert property (@(posedge clk) disable iff (!rstN)
    !errReqValid |=> $stable(errFlags));
  a_r5_gated: assert property (@(posedge clk) disable iff (!rstN)
    gerrPulse |-> $past(gerrIrqEn && errReqValid));
  a_r6_ack_store: assert property (@(posedge clk) disable iff (!rstN)
    ackWrEn |=> ackFlags == $past(ackWrData));
  a_r8_evt_gate: assert property (@(posedge clk) disable iff (!rstN)
    evtPulse |-> $past(evtReq && evtIrqEn));
  a_r9_sync_always: assert property (@(posedge clk) disable iff (!rstN)
    syncReq |=> syncPulse);
  a_r10_page_quiet: assert property (@(posedge clk) disable iff (!rstN)
    pageReq |=> !pagePulse);
endmodule

bind toggle_err_unit toggle_err_checker #(.ERR_W(ERR_W)) u_chk (
  .clk(clk), .rstN(rstN), .errReqValid(errReqValid), .errReqMask(errReqMask),
  .ackWrEn(ackWrEn), .ackWrData(ackWrData), .gerrIrqEn(gerrIrqEn),
  .evtIrqEn(evtIrqEn), .evtReq(evtReq), .syncReq(syncReq), .pageReq(pageReq),
  .errFlags(errFlags), .ackFlags(ackFlags), .gerrPulse(gerrPulse),
  .evtPulse(evtPulse), .syncPulse(syncPulse), .pagePulse(pagePulse)
);

// File: tb/toggle_err_unit_test.sv
`timescale 1ns/1ps
module toggle_err_unit_test;
  localparam int W = 4;
  logic clk = 0, rstN = 0;
  logic errReqValid = 0, ackWrEn = 0, gerrIrqEn = 0, evtIrqEn = 0;
  logic evtReq = 0, syncReq = 0, pageReq = 0;
  logic [W-1:0] errReqMask = '0, ackWrData = '0;
  logic [W-1:0] errFlags, ackFlags, pendingFlags;
  logic gerrPulse, evtPulse, syncPulse, pagePulse, ackMisuse;
  int errors = 0, checks = 0;
  logic [W-1:0] errM = '0, ackM = '0;
  logic expG, expMis;

  always #2 clk = ~clk;

  toggle_err_unit #(.ERR_W(W)) uut (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(logic req, logic [W-1:0] m, logic wr, logic [W-1:0] d, logic en);
    logic [W-1:0] ackN, tog;
    errReqValid = req; errReqMask = m; ackWrEn = wr; ackWrData = d; gerrIrqEn = en;
    ackN   = wr ? d : ackM;
    tog    = req ? (m & ~(errM ^ ackN)) : '0;
    expMis = wr && (((ackM ^ d) & ~(errM ^ ackM)) != 0);
    expG   = req && (tog != 0) && en;
    errM   = errM ^ tog;
    ackM   = ackN;
    @(negedge clk);
    chk("R3 R11 errFlags", errFlags, errM);
    chk("R6 ackFlags", ackFlags, ackM);
    chk("R2 pendingFlags", pendingFlags, errM ^ ackM);
    chk("R4 R5 gerrPulse", gerrPulse, expG);
    chk("R7 ackMisuse", ackMisuse, expMis);
  endtask

  initial begin
    #20000000;
    errors++; checks++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 errFlags", errFlags, 0);
    chk("R1 ackFlags", ackFlags, 0);
    chk("R1 pulses", {gerrPulse, evtPulse, syncPulse, pagePulse, ackMisuse}, 0);
    rstN = 1;
    @(negedge clk);
    // R4: a zero mask changes nothing
    step(1, 4'h0, 0, 4'h0, 1);
    // R5: new bits with enable give a pulse, and the pulse lasts one cycle
    step(1, 4'h5, 0, 4'h0, 1);
    step(0, 4'h0, 0, 4'h0, 1);
    chk("R5 one cycle", gerrPulse, 0);
    // R4: the same bits are now pending, so no change and no pulse
    step(1, 4'h5, 0, 4'h0, 1);
    // R11: acknowledge and request in the same cycle re-raise bit 0
    step(1, 4'h1, 1, 4'h1, 1);
    // R7: inverting bit 3, which is not pending, sets the misuse flag
    step(0, 4'h0, 1, 4'h9, 0);
    // exhaustive sweep
    for (int i = 0; i < 2048; i++)
      step(i[9], i[3:0], i[8], i[7:4] ^ i[3:0], i[10]);
    // R8 R9 R10: all enable and request combinations
    for (int k = 0; k < 16; k++) begin
      evtIrqEn = k[0]; evtReq = k[1]; syncReq = k[2]; pageReq = k[3];
      gerrIrqEn = 1; errReqValid = 0; ackWrEn = 0;
      @(negedge clk);
      chk("R8 evtPulse", evtPulse, k[0] & k[1]);
      chk("R9 syncPulse", syncPulse, k[2]);
      chk("R10 pagePulse", pagePulse, 0);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule